// File: doc/BRIEF.md
# Register-Immediate Integer ALU Unit

This block is the combinational execute stage of a 32-bit load-store integer core. It receives the fields of an already decoded instruction: a 6-bit major opcode, a 6-bit function selector, a 5-bit shift distance, two 32-bit register operands and a 16-bit immediate. In the same cycle it returns a 32-bit result, a write-enable for the destination register and a flag that tells whether the result is zero.

When the major opcode is all zeros, the function selector picks the operation and both operands come from registers. Any other opcode selects an immediate form. The immediate then takes the place of the second register operand, and it is sign- or zero-extended according to the operation. Shifts move the second register operand. The distance comes either from the instruction's shift field or from the low bits of the first register operand. Codes outside the supported set give a zero result and no write. Multiply, divide, branches, memory access and overflow traps are handled elsewhere.

Top module: `rialu_exec`

## Requirements
- R1: With opcode 000000, function 100000 or 100001 returns rs+rt and function 100010 or 100011 returns rs-rt. Both wrap modulo 2^32 and never trap. The immediate and shift fields have no effect.
- R2: With opcode 000000, function 100100 returns rs AND rt, 100101 returns rs OR rt, 100110 returns rs XOR rt and 100111 returns NOT(rs OR rt).
- R3: With opcode 000000, function 101010 returns 1 when rs < rt as two's complement values and 0 otherwise. Function 101001 makes the same comparison on unsigned values. Bits 31..1 of the result are always zero.
- R4: Opcodes 001000 (add) and 001010 (signed set-less-than) sign-extend the immediate to 32 bits. Opcodes 001100 (AND), 001101 (OR) and 001110 (XOR) zero-extend it. The extended immediate replaces rt, and the function field has no effect.
- R5: With opcode 000000, functions 000000, 000010 and 000011 shift rt left, logical right and arithmetic right by the 5-bit shift field. The value of rs has no effect.
- R6: With opcode 000000, functions 000100, 000110 and 000111 shift rt left, logical right and arithmetic right by rs[4:0]. The upper bits of rs and the shift field have no effect.
- R7: Arithmetic right shifts fill the vacated positions with rt[31]. Logical right and left shifts fill them with zeros.
- R8: Any other function code under opcode 000000, and any opcode not listed, gives result 0 and write-enable 0.
- R9: Write-enable is 1 for every recognised operation. The zero flag is 1 exactly when the result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Major opcode of the instruction |
| funct | input | 6 | Function selector, used when opcode is 000000 |
| shamt | input | 5 | Fixed shift distance |
| rs_val | input | 32 | First register operand |
| rt_val | input | 32 | Second register operand |
| imm | input | 16 | Immediate field |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Destination write-enable |
| zero | output | 1 | High when result equals zero |

## Verification
The block holds no state. A wrong decode, a wrong extension choice or a wrong shift source therefore shows at `result` or `wr_en` in the same cycle as the faulty input, and shows nowhere else. Each code point is driven with operands that make a neighbouring mistake visible. Examples are sign bits set in immediates that should be zero-extended, rs values with upper bits set for variable shifts, and stray shift fields on arithmetic operations. A mix-up between signed and unsigned comparison, or between the two right shifts, then changes the output value rather than hiding behind a coincidence.

// File: rtl/rialu_pkg.sv
package rialu_pkg;
  localparam int XLEN_D = 32;
  localparam int IMMW_D = 16;
  localparam int CODEW_D = 6;

  typedef enum logic [3:0] {
    OP_NONE, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOR,
    OP_SLT, OP_SLTU, OP_SLL, OP_SRL, OP_SRA
  } alu_op_e;

  typedef struct packed {
    alu_op_e op;
    logic    use_imm;
    logic    ext_zero;
    logic    var_shift;
    logic    valid;
  } dec_t;
endpackage

// File: rtl/rialu_decode.sv
module rialu_decode
  import rialu_pkg::*;
#(
  parameter int CODEW = CODEW_D
) (
  input  logic [CODEW-1:0] opcode,
  input  logic [CODEW-1:0] funct,
  output dec_t             dec
);
  always_comb begin
    dec = '0;
    dec.op = OP_NONE;
    if (opcode == '0) begin
      case (funct)
        6'h20, 6'h21: dec.op = OP_ADD;
        6'h22, 6'h23: dec.op = OP_SUB;
        6'h24: dec.op = OP_AND;
        6'h25: dec.op = OP_OR;
        6'h26: dec.op = OP_XOR;
        6'h27: dec.op = OP_NOR;
        6'h2A: dec.op = OP_SLT;
        6'h29: dec.op = OP_SLTU;
        6'h00: dec.op = OP_SLL;
        6'h02: dec.op = OP_SRL;
        6'h03: dec.op = OP_SRA;
        6'h04: begin dec.op = OP_SLL; dec.var_shift = 1'b1; end
        6'h06: begin dec.op = OP_SRL; dec.var_shift = 1'b1; end
        6'h07: begin dec.op = OP_SRA; dec.var_shift = 1'b1; end
        default: dec.op = OP_NONE;
      endcase
    end else begin
      dec.use_imm = 1'b1;
      case (opcode)
        6'h08: dec.op = OP_ADD;
        6'h0A: dec.op = OP_SLT;
        6'h0C: begin dec.op = OP_AND; dec.ext_zero = 1'b1; end
        6'h0D: begin dec.op = OP_OR;  dec.ext_zero = 1'b1; end
        6'h0E: begin dec.op = OP_XOR; dec.ext_zero = 1'b1; end
        default: dec.op = OP_NONE;
      endcase
    end
    dec.valid = (dec.op != OP_NONE);
  end
endmodule

// File: rtl/rialu_operands.sv
module rialu_operands #(
  parameter int XLEN = 32,
  parameter int IMMW = 16,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic            use_imm,
  input  logic            ext_zero,
  input  logic            var_shift,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  input  logic [IMMW-1:0] imm,
  input  logic [SHW-1:0]  shamt,
  output logic [XLEN-1:0] opa,
  output logic [XLEN-1:0] opb,
  output logic [SHW-1:0]  amt
);
  logic            fill;
  logic [XLEN-1:0] imm_ext;

  assign fill    = ext_zero ? 1'b0 : imm[IMMW-1];
  assign imm_ext = {{(XLEN-IMMW){fill}}, imm};
  assign opa     = rs_val;
  assign opb     = use_imm ? imm_ext : rt_val;
  assign amt     = var_shift ? rs_val[SHW-1:0] : shamt;
endmodule

// File: rtl/rialu_core.sv
module rialu_core
  import rialu_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [SHW-1:0]  amt,
  output logic [XLEN-1:0] res
);
  function automatic logic lt_fn(input logic [XLEN-1:0] x, input logic [XLEN-1:0] y,
                                 input logic is_signed);
    if (is_signed && (x[XLEN-1] != y[XLEN-1])) return x[XLEN-1];
    return x < y;
  endfunction

  function automatic logic [XLEN-1:0] sar_fn(input logic [XLEN-1:0] x, input logic [SHW-1:0] n);
    logic [2*XLEN-1:0] wide;
    wide = {{XLEN{x[XLEN-1]}}, x} >> n;
    return wide[XLEN-1:0];
  endfunction

  always_comb begin
    case (op)
      OP_ADD:  res = a + b;
      OP_SUB:  res = a - b;
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_NOR:  res = ~(a | b);
      OP_SLT:  res = {{(XLEN-1){1'b0}}, lt_fn(a, b, 1'b1)};
      OP_SLTU: res = {{(XLEN-1){1'b0}}, lt_fn(a, b, 1'b0)};
      OP_SLL:  res = b << amt;
      OP_SRL:  res = b >> amt;
      OP_SRA:  res = sar_fn(b, amt);
      default: res = '0;
    endcase
  end

  always_comb begin
    // R3
    slt_narrow_chk: assert (!(op == OP_SLT || op == OP_SLTU) || res[XLEN-1:1] == '0)
      else $error("compare result wider than one bit");
    // R7
    sra_fill_chk: assert (!(op == OP_SRA && b[XLEN-1]) || res[XLEN-1])
      else $error("arithmetic shift lost sign fill");
    // R7
    srl_fill_chk: assert (!(op == OP_SRL && amt != '0) || !res[XLEN-1])
      else $error("logical shift filled with one");
  end
endmodule

// File: rtl/rialu_exec.sv
module rialu_exec
  import rialu_pkg::*;
#(
  parameter int XLEN  = XLEN_D,
  parameter int IMMW  = IMMW_D,
  parameter int CODEW = CODEW_D,
  localparam int SHW  = $clog2(XLEN)
) (
  input  logic [CODEW-1:0] opcode,
  input  logic [CODEW-1:0] funct,
  input  logic [SHW-1:0]   shamt,
  input  logic [XLEN-1:0]  rs_val,
  input  logic [XLEN-1:0]  rt_val,
  input  logic [IMMW-1:0]  imm,
  output logic [XLEN-1:0]  result,
  output logic             wr_en,
  output logic             zero
);
  dec_t            dec;
  logic [XLEN-1:0] opa, opb;
  logic [SHW-1:0]  amt;

  rialu_decode #(.CODEW(CODEW)) u_dec (.opcode(opcode), .funct(funct), .dec(dec));

  rialu_operands #(.XLEN(XLEN), .IMMW(IMMW)) u_opnd (
    .use_imm(dec.use_imm), .ext_zero(dec.ext_zero), .var_shift(dec.var_shift),
    .rs_val(rs_val), .rt_val(rt_val), .imm(imm), .shamt(shamt),
    .opa(opa), .opb(opb), .amt(amt));

  rialu_core #(.XLEN(XLEN)) u_core (.op(dec.op), .a(opa), .b(opb), .amt(amt), .res(result));

  assign wr_en = dec.valid;
  assign zero  = (result == '0);

  always_comb begin
    // R8
    no_write_zero_chk: assert (wr_en || result == '0)
      else $error("unrecognised code produced a value");
    // R4
    andi_upper_chk: assert (!(dec.use_imm && dec.op == OP_AND) || result[XLEN-1:IMMW] == '0)
      else $error("zero-extended AND leaked upper bits");
  end
endmodule

// File: tb/test_rialu_exec.sv
module test_rialu_exec;
  typedef struct packed {
    logic [5:0]  opc;
    logic [5:0]  fn;
    logic [4:0]  sh;
    logic [31:0] a;
    logic [31:0] b;
    logic [15:0] im;
    logic [31:0] res;
    logic        we;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    // R1
    '{6'h00, 6'h20, 5'd31, 32'd5,         32'd7,         16'hFFFF, 32'd12,        1'b1, 4'd1},
    '{6'h00, 6'h21, 5'd0,  32'hFFFFFFFF,  32'd2,         16'h0000, 32'd1,         1'b1, 4'd1},
    '{6'h00, 6'h22, 5'd7,  32'd3,         32'd5,         16'h1234, 32'hFFFFFFFE,  1'b1, 4'd1},
    '{6'h00, 6'h23, 5'd0,  32'h80000000,  32'd1,         16'h0000, 32'h7FFFFFFF,  1'b1, 4'd1},
    // R2
    '{6'h00, 6'h24, 5'd0,  32'hF0F0FF00,  32'h0FF0F0F0,  16'h0000, 32'h00F0F000,  1'b1, 4'd2},
    '{6'h00, 6'h25, 5'd0,  32'hF0000000,  32'h0000000F,  16'h0000, 32'hF000000F,  1'b1, 4'd2},
    '{6'h00, 6'h26, 5'd0,  32'hFFFF0000,  32'h0F0F0F0F,  16'h0000, 32'hF0F00F0F,  1'b1, 4'd2},
    '{6'h00, 6'h27, 5'd0,  32'h00000000,  32'h0000FFFF,  16'h0000, 32'hFFFF0000,  1'b1, 4'd2},
    // R3
    '{6'h00, 6'h2A, 5'd0,  32'hFFFFFFFF,  32'd1,         16'h0000, 32'd1,         1'b1, 4'd3},
    '{6'h00, 6'h29, 5'd0,  32'hFFFFFFFF,  32'd1,         16'h0000, 32'd0,         1'b1, 4'd3},
    '{6'h00, 6'h2A, 5'd0,  32'd5,         32'd5,         16'h0000, 32'd0,         1'b1, 4'd3},
    // R4
    '{6'h08, 6'h22, 5'd0,  32'd10,        32'd99,        16'hFFFF, 32'd9,         1'b1, 4'd4},
    '{6'h0A, 6'h00, 5'd0,  32'h80000000,  32'd0,         16'h8000, 32'd1,         1'b1, 4'd4},
    '{6'h0C, 6'h00, 5'd0,  32'hFFFFFFFF,  32'd0,         16'h8001, 32'h00008001,  1'b1, 4'd4},
    '{6'h0D, 6'h00, 5'd0,  32'h12340000,  32'hFFFFFFFF,  16'hFFFF, 32'h1234FFFF,  1'b1, 4'd4},
    '{6'h0E, 6'h00, 5'd0,  32'hFFFFFFFF,  32'd0,         16'h00FF, 32'hFFFFFF00,  1'b1, 4'd4},
    // R5
    '{6'h00, 6'h00, 5'd4,  32'h0000001F,  32'd3,         16'h0000, 32'h00000030,  1'b1, 4'd5},
    '{6'h00, 6'h02, 5'd31, 32'h00000001,  32'h80000000,  16'h0000, 32'd1,         1'b1, 4'd5},
    // R7
    '{6'h00, 6'h03, 5'd4,  32'd0,         32'h80000000,  16'h0000, 32'hF8000000,  1'b1, 4'd7},
    '{6'h00, 6'h03, 5'd31, 32'd0,         32'h7FFFFFFF,  16'h0000, 32'd0,         1'b1, 4'd7},
    // R6
    '{6'h00, 6'h04, 5'd9,  32'h00000024,  32'd1,         16'h0000, 32'h00000010,  1'b1, 4'd6},
    '{6'h00, 6'h06, 5'd0,  32'hFFFFFFE1,  32'h80000000,  16'h0000, 32'h40000000,  1'b1, 4'd6},
    '{6'h00, 6'h07, 5'd0,  32'h0000001F,  32'h80000000,  16'h0000, 32'hFFFFFFFF,  1'b1, 4'd6},
    // R8
    '{6'h00, 6'h0F, 5'd0,  32'd1,         32'd2,         16'h0001, 32'd0,         1'b0, 4'd8},
    '{6'h3F, 6'h20, 5'd0,  32'd1,         32'd2,         16'h0001, 32'd0,         1'b0, 4'd8},
    '{6'h00, 6'h18, 5'd0,  32'd3,         32'd3,         16'h0000, 32'd0,         1'b0, 4'd8},
    '{6'h09, 6'h00, 5'd0,  32'd3,         32'd3,         16'h0004, 32'd0,         1'b0, 4'd8}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0]  opcode, funct;
  logic [4:0]  shamt;
  logic [31:0] rs_val, rt_val, result;
  logic [15:0] imm;
  logic        wr_en, zero;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rialu_exec i_rialu_exec (
    .opcode(opcode), .funct(funct), .shamt(shamt), .rs_val(rs_val), .rt_val(rt_val),
    .imm(imm), .result(result), .wr_en(wr_en), .zero(zero));

  task automatic apply(input vec_t v);
    @(negedge clk);
    opcode = v.opc; funct = v.fn; shamt = v.sh;
    rs_val = v.a; rt_val = v.b; imm = v.im;
    #2;
  endtask

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    opcode = '0; funct = '0; shamt = '0; rs_val = '0; rt_val = '0; imm = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #2;
    // idle inputs decode as a zero-distance left shift of zero (R5, R9)
    check32("R5 idle result", result, 32'd0);
    check32("R9 idle wr_en", {31'd0, wr_en}, 32'd1);
    check32("R9 idle zero", {31'd0, zero}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      string tag;
      apply(VEC[i]);
      tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
      check32({tag, " result"}, result, VEC[i].res);
      check32({"R9 ", tag, " wr_en"}, {31'd0, wr_en}, {31'd0, VEC[i].we});
      check32({"R9 ", tag, " zero"}, {31'd0, zero}, {31'd0, (VEC[i].res == 32'd0)});
    end

    // R7 left shift fills low bits with zero
    apply('{6'h00, 6'h00, 5'd31, 32'd0, 32'hFFFFFFFF, 16'h0, 32'd0, 1'b1, 4'd7});
    check32("R7 sll fill", result, 32'h80000000);
    // R6 variable shift ignores rs upper bits: rs=0x20 means distance 0
    apply('{6'h00, 6'h06, 5'd3, 32'h00000020, 32'hA5A5A5A5, 16'h0, 32'd0, 1'b1, 4'd6});
    check32("R6 count wrap", result, 32'hA5A5A5A5);
    // R4 slti sign-extends: 5 < -1 is false, unsigned view would be true
    apply('{6'h0A, 6'h00, 5'd0, 32'd5, 32'd0, 16'hFFFF, 32'd0, 1'b1, 4'd4});
    check32("R4 slti signed", result, 32'd0);
    // R1 add with zero result raises zero flag
    apply('{6'h00, 6'h20, 5'd0, 32'h00000001, 32'hFFFFFFFF, 16'h0, 32'd0, 1'b1, 4'd1});
    check32("R1 add wrap to zero", result, 32'd0);
    check32("R9 zero on add", {31'd0, zero}, 32'd1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule